// File: doc/BRIEF.md
# Host Mailbox Command Processor with Dual Coefficient Upload

This block sits behind a small host register window: a command register, two data registers and a control/status view. The host stores a command code and operands, and then writes the second data register to start a transaction. While the engine side handles the transaction, a request flag stays high. The host must wait for that flag to drop before it writes again. Three commands are decoded: store a value into an internal register file, fetch a value from that register file, and upload coefficients for two FIR filters.

The upload command is sent once and carries two counts, one per filter. After it completes, every transaction made by writing the two data registers delivers two coefficients: the first data register holds the earlier one, the second holds the later one. The coefficients form a single stream that fills the first filter's memory and then the second's. The filter datapath reads the loaded lengths and the coefficient memories through a dedicated read port.

Top module: `mbox_cmd_proc`

## Requirements
- R1: With command value 0x01, a transaction stores the second data register into the register file entry addressed by the first data register. An address at or beyond the register count stores nothing.
- R2: With command value 0x02, a transaction replaces the first data register with the addressed register file entry, or with zero when the address is out of range. The second data register does not affect the result and changes no register file entry.
- R3: A host write of the second data register, made while the request flag is low, starts a transaction. The request flag is high from the next cycle, stays high for exactly two cycles and then clears, at which point the transaction's effect is visible.
- R4: Host writes to the command or data registers while the request flag is high are dropped and set the sticky overflow flag. Writing the control register with bit 1 set clears that flag.
- R5: A transaction whose command value is not 0x01, 0x02 or 0x03 changes no register. It clears the request flag like any other transaction and sets the sticky error flag. Writing the control register with bit 0 set clears the error flag.
- R6: With command value 0x03, a transaction loads the first data register as the first filter's coefficient count and the second data register as the second filter's count. Both counts appear on the length outputs, and the upload mode is entered if either count is nonzero.
- R7: In upload mode, each transaction writes the first data register and then the second data register into the next stream positions. Positions below the first count go to the first filter's memory at that index; the following positions go to the second filter's memory, starting from index 0.
- R8: When the combined count is odd, the second word of the final upload transaction is written nowhere. Upload mode ends on the transaction that reaches the combined count.
- R9: A zero count skips that filter. With both counts zero, upload mode is never entered, and the next transaction is decoded as a command.
- R10: While upload mode is active, writing any value to the command register does not alter the upload sequence.
- R11: A count value above 255 is saturated to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_sel | input | 2 | Write target: 0 command, 1 first data, 2 second data, 3 control |
| wr_data | input | DW (24) | Host write value |
| cmd_q | output | DW | Command register contents |
| dat1_q | output | DW | First data register contents (read results land here) |
| dat2_q | output | DW | Second data register contents |
| req | output | 1 | Request flag: transaction pending |
| err | output | 1 | Sticky unknown-command flag |
| ovf | output | 1 | Sticky dropped-write flag |
| upload_active | output | 1 | Coefficient upload mode |
| fir1_len | output | 8 | Loaded first-filter count |
| fir2_len | output | 8 | Loaded second-filter count |
| coef_rd_fir | input | 1 | Coefficient read bank select (0 first, 1 second) |
| coef_rd_idx | input | 8 | Coefficient read index |
| coef_rd_data | output | DW | Coefficient read data |

## Verification
The assertions watch, on every cycle, the request handshake: it rises after a trigger, stays high for a bounded time, sets the overflow flag on a dropped write, keeps the sticky flags until they are cleared, and is low when upload mode ends. They also check that the stream position stays below the combined count during an upload. Only the bench's scenarios can show where each data word ends up. These scenarios cover register contents after write and read commands, the split between the two coefficient memories, the discarded final word, skipped filters, count saturation, and immunity to command rewrites during an upload.

// File: rtl/mbox_pkg.sv
// Shared encodings for the mailbox command processor.
// Assumes: command codes occupy the full command register value.
package mbox_pkg;
    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_DAT1 = 2'd1,
        SEL_DAT2 = 2'd2,
        SEL_CTRL = 2'd3
    } win_sel_e;

    localparam logic [7:0] OP_WRITE  = 8'h01;
    localparam logic [7:0] OP_READ   = 8'h02;
    localparam logic [7:0] OP_UPLOAD = 8'h03;
endpackage

// File: rtl/mbox_window.sv
// Host register window: command and data registers, request flag with a
// fixed acceptance latency, and sticky error / overflow flags.
// Assumes: at most one host write per cycle; LAT >= 1.
module mbox_window #(
    parameter int DW  = 24,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_load,
    input  logic [DW-1:0] rd_value,
    input  logic          err_set,
    output logic [DW-1:0] cmd_q,
    output logic [DW-1:0] dat1_q,
    output logic [DW-1:0] dat2_q,
    output logic          req_q,
    output logic          err_q,
    output logic          ovf_q,
    output logic          accept
);
    import mbox_pkg::*;

    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] lat_cnt;
    win_sel_e      sel;

    assign sel    = win_sel_e'(wr_sel);
    assign accept = req_q && (lat_cnt == CW'(1));

    // Register window writes, request pacing and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            dat1_q  <= '0;
            dat2_q  <= '0;
            req_q   <= 1'b0;
            lat_cnt <= '0;
            err_q   <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            if (req_q) begin
                lat_cnt <= lat_cnt - CW'(1);
                if (accept) req_q <= 1'b0;
            end
            if (rd_load) dat1_q <= rd_value;
            if (wr_en) begin
                if (sel == SEL_CTRL) begin
                    if (wr_data[0]) err_q <= 1'b0;
                    if (wr_data[1]) ovf_q <= 1'b0;
                end else if (req_q) begin
                    ovf_q <= 1'b1;
                end else begin
                    case (sel)
                        SEL_CMD:  cmd_q  <= wr_data;
                        SEL_DAT1: dat1_q <= wr_data;
                        default: begin
                            dat2_q  <= wr_data;
                            req_q   <= 1'b1;
                            lat_cnt <= CW'(LAT);
                        end
                    endcase
                end
            end
            if (err_set) err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/mbox_coef_bank.sv
// Coefficient memory with two write ports (applied in one cycle) and one
// asynchronous read port. Assumes the two write addresses differ when both
// ports write in the same cycle.
module mbox_coef_bank #(
    parameter int DEPTH = 255,
    parameter int AW    = 8,
    parameter int DW    = 24
) (
    input  logic                 clk,
    input  logic [1:0]           we,
    input  logic [1:0][AW-1:0]   waddr,
    input  logic [1:0][DW-1:0]   wdata,
    input  logic [AW-1:0]        raddr,
    output logic [DW-1:0]        rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Apply both write ports.
    always_ff @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            if (we[p] && (32'(waddr[p]) < DEPTH)) mem[waddr[p]] <= wdata[p];
        end
    end

    // Guarded asynchronous read.
    always_comb begin
        rdata = '0;
        if (32'(raddr) < DEPTH) rdata = mem[raddr];
    end
endmodule

// File: rtl/mbox_cmd_proc.sv
// Mailbox command processor: decodes register write/read and the two-filter
// coefficient upload, holds the register file and the upload stream position.
// Assumes: MAXC fits in CNTW bits; coefficient width equals DW.
module mbox_cmd_proc #(
    parameter int DW      = 24,
    parameter int NREG    = 16,
    parameter int MAXC    = 255,
    parameter int ACC_LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] cmd_q,
    output logic [DW-1:0] dat1_q,
    output logic [DW-1:0] dat2_q,
    output logic          req,
    output logic          err,
    output logic          ovf,
    output logic          upload_active,
    output logic [7:0]    fir1_len,
    output logic [7:0]    fir2_len,
    input  logic          coef_rd_fir,
    input  logic [7:0]    coef_rd_idx,
    output logic [DW-1:0] coef_rd_data
);
    import mbox_pkg::*;

    localparam int RAW  = $clog2(NREG);
    localparam int CNTW = 8;
    localparam int PW   = CNTW + 1;

    logic             accept, rd_load, err_set, addr_ok;
    logic [DW-1:0]    rd_value;
    logic [DW-1:0]    regs [NREG];
    logic [RAW-1:0]   ridx;
    logic [CNTW-1:0]  n1_q, n2_q, cnt1, cnt2;
    logic [PW-1:0]    pos_q, total_w;
    logic             active_q, step, is_known;
    logic [1:0]       to1, to2;
    logic [1:0][CNTW-1:0] a1, a2;
    logic [1:0][DW-1:0]   words;
    logic [1:0][DW-1:0]   bank_rd;

    mbox_window #(.DW(DW), .LAT(ACC_LAT)) u_win (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_load(rd_load), .rd_value(rd_value),
        .err_set(err_set), .cmd_q(cmd_q), .dat1_q(dat1_q), .dat2_q(dat2_q),
        .req_q(req), .err_q(err), .ovf_q(ovf), .accept(accept)
    );

    // Command decode helpers and count saturation.
    always_comb begin
        addr_ok  = dat1_q < DW'(NREG);
        ridx     = dat1_q[RAW-1:0];
        rd_value = addr_ok ? regs[ridx] : '0;
        is_known = (cmd_q == DW'(OP_WRITE)) || (cmd_q == DW'(OP_READ)) ||
                   (cmd_q == DW'(OP_UPLOAD));
        rd_load  = accept && !active_q && (cmd_q == DW'(OP_READ));
        err_set  = accept && !active_q && !is_known;
        cnt1     = (dat1_q > DW'(MAXC)) ? CNTW'(MAXC) : dat1_q[CNTW-1:0];
        cnt2     = (dat2_q > DW'(MAXC)) ? CNTW'(MAXC) : dat2_q[CNTW-1:0];
        total_w  = {1'b0, n1_q} + {1'b0, n2_q};
        step     = accept && active_q;
        words[0] = dat1_q;
        words[1] = dat2_q;
    end

    // Map the two stream positions of this transaction onto the banks.
    for (genvar k = 0; k < 2; k++) begin : g_slot
        logic [PW-1:0] sp;
        always_comb begin
            sp     = pos_q + PW'(k);
            to1[k] = sp < {1'b0, n1_q};
            to2[k] = !to1[k] && (sp < total_w);
            a1[k]  = sp[CNTW-1:0];
            a2[k]  = CNTW'(sp - {1'b0, n1_q});
        end
    end

    // Two coefficient banks, one per filter.
    for (genvar f = 0; f < 2; f++) begin : g_bank
        logic [1:0] bwe;
        assign bwe = (f == 0) ? (to1 & {2{step}}) : (to2 & {2{step}});
        mbox_coef_bank #(.DEPTH(MAXC), .AW(CNTW), .DW(DW)) u_bank (
            .clk(clk), .we(bwe), .waddr((f == 0) ? a1 : a2), .wdata(words),
            .raddr(coef_rd_idx), .rdata(bank_rd[f])
        );
    end

    assign coef_rd_data  = bank_rd[coef_rd_fir];
    assign upload_active = active_q;
    assign fir1_len      = n1_q;
    assign fir2_len      = n2_q;

    // Register file, upload counts and stream position on each accepted transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
            n1_q     <= '0;
            n2_q     <= '0;
            pos_q    <= '0;
            active_q <= 1'b0;
        end else if (accept) begin
            if (active_q) begin
                pos_q <= pos_q + PW'(2);
                if (pos_q + PW'(2) >= total_w) active_q <= 1'b0;
            end else if (cmd_q == DW'(OP_WRITE)) begin
                if (addr_ok) regs[ridx] <= dat2_q;
            end else if (cmd_q == DW'(OP_UPLOAD)) begin
                n1_q     <= cnt1;
                n2_q     <= cnt2;
                pos_q    <= '0;
                active_q <= (cnt1 != '0) || (cnt2 != '0);
            end
        end
    end
endmodule

// File: rtl/mbox_cmd_proc_sva.sv
// Protocol checker for the mailbox command processor, bound to the top.
// Assumes the default acceptance latency window is held in LAT.
module mbox_cmd_proc_checker #(
    parameter int LAT = 2,
    parameter int PW  = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_sel,
    input logic          clr_err_bit,
    input logic          clr_ovf_bit,
    input logic          req,
    input logic          err,
    input logic          ovf,
    input logic          upload_active,
    input logic [PW-1:0] pos,
    input logic [PW-1:0] total
);
    int unsigned run;

    // Count consecutive cycles the request flag has already been high.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 0;
        else        run <= req ? run + 1 : 0;
    end

    assert_req_on_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2 && !req) |=> req);

    assert_req_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (run < LAT));

    assert_ovf_on_busy_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && req && wr_sel != 2'd3) |=> ovf);

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(wr_en && wr_sel == 2'd3 && clr_ovf_bit)) |=> ovf);

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(wr_en && wr_sel == 2'd3 && clr_err_bit)) |=> err);

    assert_pos_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upload_active |-> (pos < total));

    assert_upload_end_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upload_active) |-> !req);
endmodule

bind mbox_cmd_proc mbox_cmd_proc_checker #(.LAT(ACC_LAT), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .clr_err_bit(wr_data[0]), .clr_ovf_bit(wr_data[1]),
    .req(req), .err(err), .ovf(ovf), .upload_active(upload_active),
    .pos(pos_q), .total(total_w)
);

// File: tb/mbox_cmd_proc_bench.sv
// Directed bench for the mailbox command processor: one task per scenario.
module mbox_cmd_proc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [DW-1:0] wr_data = '0;
    logic          coef_rd_fir = 1'b0;
    logic [7:0]    coef_rd_idx = '0;
    logic [DW-1:0] cmd_q, dat1_q, dat2_q, coef_rd_data;
    logic          req, err, ovf, upload_active;
    logic [7:0]    fir1_len, fir2_len;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbox_cmd_proc u_mbox_cmd_proc (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cmd_q(cmd_q), .dat1_q(dat1_q), .dat2_q(dat2_q),
        .req(req), .err(err), .ovf(ovf), .upload_active(upload_active),
        .fir1_len(fir1_len), .fir2_len(fir2_len), .coef_rd_fir(coef_rd_fir),
        .coef_rd_idx(coef_rd_idx), .coef_rd_data(coef_rd_data)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(logic [1:0] sel, logic [DW-1:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (req) @(negedge clk);
    endtask

    task automatic do_cmd(logic [DW-1:0] c, logic [DW-1:0] d1, logic [DW-1:0] d2);
        host_write(2'd0, c);
        host_write(2'd1, d1);
        host_write(2'd2, d2);
        wait_idle();
    endtask

    task automatic burst(logic [DW-1:0] d1, logic [DW-1:0] d2);
        host_write(2'd1, d1);
        host_write(2'd2, d2);
        wait_idle();
    endtask

    task automatic read_reg(logic [DW-1:0] addr, output logic [DW-1:0] val);
        do_cmd(24'h02, addr, 24'h0);
        val = dat1_q;
    endtask

    task automatic coef(bit fir, int idx, output logic [DW-1:0] val);
        coef_rd_fir = fir; coef_rd_idx = 8'(idx);
        #1;
        val = coef_rd_data;
    endtask

    task automatic t_reset();
        check("R3 reset req", {31'b0, req}, 0);
        check("R5 reset err", {31'b0, err}, 0);
        check("R4 reset ovf", {31'b0, ovf}, 0);
        check("R6 reset upload", {31'b0, upload_active}, 0);
    endtask

    task automatic t_handshake_r3();
        host_write(2'd0, 24'h01);
        host_write(2'd1, 24'd4);
        host_write(2'd2, 24'h5A5);
        check("R3 req first cycle", {31'b0, req}, 1);
        @(negedge clk);
        check("R3 req second cycle", {31'b0, req}, 1);
        @(negedge clk);
        check("R3 req cleared", {31'b0, req}, 0);
    endtask

    task automatic t_write_read_r1_r2();
        logic [DW-1:0] v;
        do_cmd(24'h01, 24'd5, 24'hABCDE);
        read_reg(24'd5, v);
        check("R1 write then read", 32'(v), 32'hABCDE);
        read_reg(24'd4, v);
        check("R3 earlier write landed", 32'(v), 32'h5A5);
        do_cmd(24'h01, 24'd40, 24'h777);
        read_reg(24'd40, v);
        check("R1 out-of-range write/read", 32'(v), 0);
        do_cmd(24'h02, 24'd5, 24'd3);
        check("R2 read ignores dat2", 32'(dat1_q), 32'hABCDE);
        read_reg(24'd3, v);
        check("R2 read stores nothing", 32'(v), 0);
    endtask

    task automatic t_overflow_r4();
        logic [DW-1:0] v;
        host_write(2'd0, 24'h01);
        host_write(2'd1, 24'd7);
        host_write(2'd2, 24'h111);
        host_write(2'd1, 24'd2);
        check("R4 ovf set", {31'b0, ovf}, 1);
        wait_idle();
        check("R4 dropped dat1 write", 32'(dat1_q), 7);
        read_reg(24'd7, v);
        check("R4 transaction intact", 32'(v), 32'h111);
        read_reg(24'd2, v);
        check("R4 dropped write no effect", 32'(v), 0);
        check("R4 ovf still sticky", {31'b0, ovf}, 1);
        host_write(2'd3, 24'h2);
        check("R4 ovf cleared", {31'b0, ovf}, 0);
    endtask

    task automatic t_unknown_r5();
        logic [DW-1:0] v;
        do_cmd(24'h44, 24'd6, 24'h999);
        check("R5 req cleared", {31'b0, req}, 0);
        check("R5 err set", {31'b0, err}, 1);
        check("R5 dat1 unchanged", 32'(dat1_q), 6);
        read_reg(24'd6, v);
        check("R5 no register change", 32'(v), 0);
        check("R5 err sticky", {31'b0, err}, 1);
        host_write(2'd3, 24'h1);
        check("R5 err cleared", {31'b0, err}, 0);
    endtask

    task automatic t_skip_r9();
        logic [DW-1:0] v;
        do_cmd(24'h03, 24'd0, 24'd0);
        check("R9 both zero stays idle", {31'b0, upload_active}, 0);
        do_cmd(24'h01, 24'd9, 24'h321);
        read_reg(24'd9, v);
        check("R9 next transaction is a command", 32'(v), 32'h321);
        do_cmd(24'h03, 24'd0, 24'd3);
        check("R9 upload entered", {31'b0, upload_active}, 1);
        burst(24'h10, 24'h11);
        burst(24'h12, 24'h99);
        check("R9 upload ended", {31'b0, upload_active}, 0);
        coef(1, 0, v); check("R9 fir2[0]", 32'(v), 32'h10);
        coef(1, 1, v); check("R9 fir2[1]", 32'(v), 32'h11);
        coef(1, 2, v); check("R9 fir2[2]", 32'(v), 32'h12);
    endtask

    task automatic t_odd_stream_r6_r7_r8();
        logic [DW-1:0] v;
        do_cmd(24'h03, 24'd3, 24'd2);
        check("R6 fir1_len", 32'(fir1_len), 3);
        check("R6 fir2_len", 32'(fir2_len), 2);
        check("R6 upload active", {31'b0, upload_active}, 1);
        burst(24'hA0, 24'hA1);
        burst(24'hA2, 24'hB0);
        check("R8 still active", {31'b0, upload_active}, 1);
        burst(24'hB1, 24'hFF);
        check("R8 ends at total", {31'b0, upload_active}, 0);
        coef(0, 0, v); check("R7 fir1[0]", 32'(v), 32'hA0);
        coef(0, 1, v); check("R7 fir1[1]", 32'(v), 32'hA1);
        coef(0, 2, v); check("R7 fir1[2]", 32'(v), 32'hA2);
        coef(1, 0, v); check("R7 fir2[0]", 32'(v), 32'hB0);
        coef(1, 1, v); check("R7 fir2[1]", 32'(v), 32'hB1);
        coef(1, 2, v); check("R8 odd word discarded", 32'(v), 32'h12);
    endtask

    task automatic t_cmd_rewrite_r10();
        logic [DW-1:0] v;
        do_cmd(24'h03, 24'd2, 24'd2);
        host_write(2'd0, 24'h02);
        burst(24'hC0, 24'hC1);
        host_write(2'd0, 24'h44);
        check("R10 still uploading", {31'b0, upload_active}, 1);
        burst(24'hD0, 24'hD1);
        check("R10 upload finished", {31'b0, upload_active}, 0);
        check("R10 no error from rewrite", {31'b0, err}, 0);
        coef(0, 0, v); check("R10 fir1[0]", 32'(v), 32'hC0);
        coef(0, 1, v); check("R10 fir1[1]", 32'(v), 32'hC1);
        coef(1, 0, v); check("R10 fir2[0]", 32'(v), 32'hD0);
        coef(1, 1, v); check("R10 fir2[1]", 32'(v), 32'hD1);
    endtask

    task automatic t_saturate_r11();
        do_cmd(24'h03, 24'd300, 24'd1);
        check("R11 fir1 saturated", 32'(fir1_len), 255);
        check("R11 fir2 unchanged", 32'(fir2_len), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake_r3();
        t_write_read_r1_r2();
        t_overflow_r4();
        t_unknown_r5();
        t_skip_r9();
        t_odd_stream_r6_r7_r8();
        t_cmd_rewrite_r10();
        t_saturate_r11();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule